// File: doc/BRIEF.md
# Conditional Branch Decision and Cycle Counter

This block sits beside the instruction decoder of an 8-bit processor core. For every control-flow instruction it receives the decoded class, a 3-bit condition selector, an enable that marks the instruction as conditional, the flag byte and the current value of the B loop counter. One clock later it reports three things: whether the branch is taken, the total number of clock cycles the instruction occupies, and the loop counter value to write back.

For a restart instruction it also supplies the fixed target vector. The block covers absolute jumps, relative jumps, the decrement-and-branch loop instruction, calls, returns and restarts. It does not fetch operands, touch the stack or compute program-counter values. The sequencer uses the cycle count to size the instruction's bus activity, and the taken bit to choose its next fetch address.

Top module: `branch_unit`

## Requirements
- R1: The condition selector picks one of eight tests on the flag byte (sign = bit 7, zero = bit 6, parity = bit 2, carry = bit 0). The codes are: 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity clear (odd), 5 parity set (even), 6 sign clear (plus), 7 sign set (minus).
- R2: With `cond_en_i` low, the jump (class 0), relative jump (class 1), call (class 3) and return (class 4) classes are always taken, whatever the flags and selector. The loop class (2) and the restart class (5) never use the condition test.
- R3: An absolute jump (class 0) reports 10 cycles whether it is taken or not.
- R4: A relative jump (class 1) reports 12 cycles when taken and 7 when not taken.
- R5: The loop class (2) outputs `count_i - 1` modulo 256. It is taken exactly when that result is nonzero, reporting 13 cycles when taken and 8 when not. Starting from 1 gives 0 and not taken; starting from 0 gives 255 and taken.
- R6: A call (class 3) reports 17 cycles when taken and 10 when not taken.
- R7: A conditional return (class 4 with `cond_en_i` high) reports 11 cycles when taken and 5 when not taken. An unconditional return reports 10.
- R8: A restart (class 5) is always taken, reports 11 cycles, and outputs a vector equal to the selector times 8. Every other class outputs a vector of zero.
- R9: Results appear one clock after `valid_i` is sampled high, together with `valid_o`. Classes other than the loop class pass `count_i` through unchanged. While `valid_i` is low, the result outputs hold their last values.
- R10: During reset every output is zero.
- R11: Class codes 6 and 7 are reserved. They produce a not-taken result with 0 cycles, a zero vector and the counter passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is presented this cycle |
| class_i | input | 3 | Control-flow class code |
| cond_en_i | input | 1 | Instruction is conditional |
| cond_sel_i | input | 3 | Condition selector, or restart index |
| flags_i | input | 8 | Flag byte |
| count_i | input | 8 | Current B counter value |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch is taken |
| cycles_o | output | 5 | Total clock cycles of the instruction |
| count_o | output | 8 | Counter value to write back |
| vector_o | output | 16 | Restart target address |

## Verification
The bench sweeps all eight selectors against flag bytes that set each tested flag alone, all together and none. A swapped sense or a wrong bit position therefore flips the taken bit for some selector.

The loop instruction is driven with starting counts of 1, 0, 2 and 255. A design that tested the counter before decrementing, or saturated at zero, would take the branch at 1 or skip it at 0.

Returns are checked in both conditional and unconditional form, so that confusing the fixed 10-cycle return with the 11-cycle taken conditional return shows up in the cycle count. Restart vectors are checked for every index. A hold check after idle cycles catches registers that update without `valid_i`.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    CLS_JP   = 3'd0,
    CLS_JR   = 3'd1,
    CLS_DJNZ = 3'd2,
    CLS_CALL = 3'd3,
    CLS_RET  = 3'd4,
    CLS_RST  = 3'd5
  } brc_class_e;

  localparam int CYC_W = 5;

  localparam logic [CYC_W-1:0] CYC_JP       = 5'd10;
  localparam logic [CYC_W-1:0] CYC_JR_TK    = 5'd12;
  localparam logic [CYC_W-1:0] CYC_JR_NT    = 5'd7;
  localparam logic [CYC_W-1:0] CYC_LOOP_TK  = 5'd13;
  localparam logic [CYC_W-1:0] CYC_LOOP_NT  = 5'd8;
  localparam logic [CYC_W-1:0] CYC_CALL_TK  = 5'd17;
  localparam logic [CYC_W-1:0] CYC_CALL_NT  = 5'd10;
  localparam logic [CYC_W-1:0] CYC_RETC_TK  = 5'd11;
  localparam logic [CYC_W-1:0] CYC_RETC_NT  = 5'd5;
  localparam logic [CYC_W-1:0] CYC_RET_UNC  = 5'd10;
  localparam logic [CYC_W-1:0] CYC_RST      = 5'd11;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval #(
  parameter int FLAG_W = 8,
  parameter int S_BIT  = 7,
  parameter int Z_BIT  = 6,
  parameter int P_BIT  = 2,
  parameter int C_BIT  = 0
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [2:0]        sel_i,
  output logic              hit_o
);
  logic picked;

  // sel[2:1] picks the flag, sel[0] picks its sense (1 = set)
  always_comb begin
    unique case (sel_i[2:1])
      2'd0:    picked = flags_i[Z_BIT];
      2'd1:    picked = flags_i[C_BIT];
      2'd2:    picked = flags_i[P_BIT];
      default: picked = flags_i[S_BIT];
    endcase
    hit_o = sel_i[0] ? picked : ~picked;
  end

  always_comb begin
    if (sel_i == 3'd1) a_r1_zero_set : assert (hit_o == flags_i[Z_BIT]);
    if (sel_i == 3'd6) a_r1_plus     : assert (hit_o == ~flags_i[S_BIT]);
  end
endmodule

// File: rtl/brc_loop_dec.sv
module brc_loop_dec #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] dec_o,
  output logic             nz_o
);
  always_comb begin
    dec_o = cnt_i - CNT_W'(1);
    nz_o  = |dec_o;
  end

  always_comb begin
    a_r5_one_ends : assert (!(cnt_i == CNT_W'(1)) || !nz_o);
  end
endmodule

// File: rtl/brc_cycle_sel.sv
module brc_cycle_sel
  import brc_pkg::*;
(
  input  logic [2:0]       class_i,
  input  logic             cond_en_i,
  input  logic             taken_i,
  output logic [CYC_W-1:0] cycles_o
);
  always_comb begin
    unique case (class_i)
      CLS_JP:   cycles_o = CYC_JP;
      CLS_JR:   cycles_o = taken_i ? CYC_JR_TK : CYC_JR_NT;
      CLS_DJNZ: cycles_o = taken_i ? CYC_LOOP_TK : CYC_LOOP_NT;
      CLS_CALL: cycles_o = taken_i ? CYC_CALL_TK : CYC_CALL_NT;
      CLS_RET:  cycles_o = !cond_en_i ? CYC_RET_UNC :
                           (taken_i ? CYC_RETC_TK : CYC_RETC_NT);
      CLS_RST:  cycles_o = CYC_RST;
      default:  cycles_o = '0;
    endcase
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import brc_pkg::*;
#(
  parameter int FLAG_W = 8,
  parameter int CNT_W  = 8,
  parameter int VEC_W  = 16,
  parameter int S_BIT  = 7,
  parameter int Z_BIT  = 6,
  parameter int P_BIT  = 2,
  parameter int C_BIT  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        class_i,
  input  logic              cond_en_i,
  input  logic [2:0]        cond_sel_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [4:0]        cycles_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [VEC_W-1:0]  vector_o
);
  localparam int VEC_PAD = VEC_W - 6;

  logic             hit;
  logic [CNT_W-1:0] dec;
  logic             dec_nz;
  logic             taken_d;
  logic [CYC_W-1:0] cyc_d;
  logic [CNT_W-1:0] cnt_d;
  logic [VEC_W-1:0] vec_d;

  brc_cond_eval #(
    .FLAG_W(FLAG_W), .S_BIT(S_BIT), .Z_BIT(Z_BIT), .P_BIT(P_BIT), .C_BIT(C_BIT)
  ) u_cond (
    .flags_i(flags_i),
    .sel_i  (cond_sel_i),
    .hit_o  (hit)
  );

  brc_loop_dec #(.CNT_W(CNT_W)) u_dec (
    .cnt_i(count_i),
    .dec_o(dec),
    .nz_o (dec_nz)
  );

  always_comb begin
    unique case (class_i)
      CLS_JP, CLS_JR, CLS_CALL, CLS_RET: taken_d = cond_en_i ? hit : 1'b1;
      CLS_DJNZ:                          taken_d = dec_nz;
      CLS_RST:                           taken_d = 1'b1;
      default:                           taken_d = 1'b0;
    endcase
    cnt_d = (class_i == CLS_DJNZ) ? dec : count_i;
    vec_d = (class_i == CLS_RST) ? {{VEC_PAD{1'b0}}, cond_sel_i, 3'b000} : '0;
  end

  brc_cycle_sel u_cyc (
    .class_i  (class_i),
    .cond_en_i(cond_en_i),
    .taken_i  (taken_d),
    .cycles_o (cyc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      taken_o  <= 1'b0;
      cycles_o <= '0;
      count_o  <= '0;
      vector_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o  <= taken_d;
        cycles_o <= cyc_d;
        count_o  <= cnt_d;
        vector_o <= vec_d;
      end
    end
  end

  a_r9_valid_lat : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r3_jp_cycles : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == CLS_JP |=> cycles_o == 5'd10);
  a_r8_rst_taken : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == CLS_RST |=> taken_o && cycles_o == 5'd11);
  a_r5_loop_count : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && class_i == CLS_DJNZ |=> count_o == $past(count_i) - CNT_W'(1));
  a_r2_unc_taken : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !cond_en_i && (class_i == CLS_JP || class_i == CLS_JR ||
    class_i == CLS_CALL || class_i == CLS_RET) |=> taken_o);
  a_r9_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cycles_o) && $stable(taken_o));
endmodule

// File: tb/branch_unit_test.sv
`timescale 1ns/1ps
module branch_unit_test;
  typedef struct {
    logic        tk;
    logic [4:0]  cyc;
    logic [7:0]  cnt;
    logic [15:0] vec;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  class_i = '0;
  logic        cond_en_i = 1'b0;
  logic [2:0]  cond_sel_i = '0;
  logic [7:0]  flags_i = '0;
  logic [7:0]  count_i = '0;
  logic        valid_o, taken_o;
  logic [4:0]  cycles_o;
  logic [7:0]  count_o;
  logic [15:0] vector_o;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];
  exp_t last;

  always #2 clk_i = ~clk_i;

  branch_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .class_i(class_i),
    .cond_en_i(cond_en_i), .cond_sel_i(cond_sel_i), .flags_i(flags_i),
    .count_i(count_i), .valid_o(valid_o), .taken_o(taken_o),
    .cycles_o(cycles_o), .count_o(count_o), .vector_o(vector_o)
  );

  function automatic logic cond_ok(input logic [2:0] s, input logic [7:0] f);
    case (s)
      3'd0: return !f[6];
      3'd1: return f[6];
      3'd2: return !f[0];
      3'd3: return f[0];
      3'd4: return !f[2];
      3'd5: return f[2];
      3'd6: return !f[7];
      default: return f[7];
    endcase
  endfunction

  function automatic exp_t model(input logic [2:0] c, input logic ce,
                                 input logic [2:0] s, input logic [7:0] f,
                                 input logic [7:0] b, input string tag);
    exp_t e;
    logic t;
    t = ce ? cond_ok(s, f) : 1'b1;
    e.tag = tag; e.cnt = b; e.vec = 16'h0;
    case (c)
      3'd0: begin e.tk = t; e.cyc = 5'd10; end
      3'd1: begin e.tk = t; e.cyc = t ? 5'd12 : 5'd7; end
      3'd2: begin
        e.cnt = b - 8'd1; e.tk = (e.cnt != 8'd0);
        e.cyc = e.tk ? 5'd13 : 5'd8;
      end
      3'd3: begin e.tk = t; e.cyc = t ? 5'd17 : 5'd10; end
      3'd4: begin e.tk = t; e.cyc = !ce ? 5'd10 : (t ? 5'd11 : 5'd5); end
      3'd5: begin e.tk = 1'b1; e.cyc = 5'd11; e.vec = 16'(s) * 16'd8; end
      default: begin e.tk = 1'b0; e.cyc = 5'd0; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] c, input logic ce, input logic [2:0] s,
                       input logic [7:0] f, input logic [7:0] b, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; class_i = c; cond_en_i = ce; cond_sel_i = s;
    flags_i = f; count_i = b;
    last = model(c, ce, s, f, b, tag);
    q.push_back(last);
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      if (rst_ni && valid_o) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R9: valid_o high with nothing expected (actual 1, expected 0)");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (taken_o !== e.tk || cycles_o !== e.cyc || count_o !== e.cnt ||
              vector_o !== e.vec) begin
            errors++;
            $display("FAIL %s: actual tk=%0b cyc=%0d cnt=%0d vec=%h, expected tk=%0b cyc=%0d cnt=%0d vec=%h",
                     e.tag, taken_o, cycles_o, count_o, vector_o, e.tk, e.cyc, e.cnt, e.vec);
          end
        end
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] fpat [6];
    fpat[0] = 8'h00; fpat[1] = 8'hC5; fpat[2] = 8'h40;
    fpat[3] = 8'h01; fpat[4] = 8'h04; fpat[5] = 8'h80;

    repeat (3) @(negedge clk_i);
    #1;
    checks++;
    if (valid_o !== 1'b0 || taken_o !== 1'b0 || cycles_o !== 5'd0 ||
        count_o !== 8'd0 || vector_o !== 16'd0) begin
      errors++;
      $display("FAIL R10: reset outputs actual v=%0b t=%0b c=%0d n=%0d vec=%h, expected all zero",
               valid_o, taken_o, cycles_o, count_o, vector_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int s = 0; s < 8; s++)
      for (int k = 0; k < 6; k++) begin
        drive(3'd0, 1'b1, 3'(s), fpat[k], 8'h33, "R1 R3 jump");
        drive(3'd1, 1'b1, 3'(s), fpat[k], 8'h44, "R1 R4 rel jump");
        drive(3'd3, 1'b1, 3'(s), fpat[k], 8'h55, "R1 R6 call");
        drive(3'd4, 1'b1, 3'(s), fpat[k], 8'h66, "R1 R7 cond return");
      end
    idle();

    for (int s = 0; s < 8; s++) begin
      drive(3'd0, 1'b0, 3'(s), 8'h00, 8'h01, "R2 uncond jump");
      drive(3'd1, 1'b0, 3'(s), 8'hFF, 8'h02, "R2 uncond rel jump");
      drive(3'd3, 1'b0, 3'(s), 8'h45, 8'h03, "R2 uncond call");
      drive(3'd4, 1'b0, 3'(s), 8'hC5, 8'h04, "R2 R7 uncond return");
    end

    drive(3'd2, 1'b1, 3'd1, 8'h00, 8'd1,   "R5 loop from 1");
    drive(3'd2, 1'b0, 3'd0, 8'hFF, 8'd0,   "R5 loop from 0");
    drive(3'd2, 1'b1, 3'd6, 8'h40, 8'd2,   "R5 loop from 2");
    drive(3'd2, 1'b0, 3'd3, 8'h01, 8'd255, "R5 loop from 255");
    idle();
    idle();

    for (int s = 0; s < 8; s++) begin
      drive(3'd5, 1'b1, 3'(s), 8'h00, 8'h77, "R8 restart");
      drive(3'd5, 1'b0, 3'(s), 8'hFF, 8'h78, "R8 restart");
    end

    drive(3'd6, 1'b1, 3'd1, 8'h40, 8'h12, "R11 reserved 6");
    drive(3'd7, 1'b0, 3'd5, 8'hFF, 8'h13, "R11 reserved 7");

    drive(3'd1, 1'b1, 3'd3, 8'h01, 8'h9A, "R9 pre-hold");
    @(negedge clk_i);
    valid_i = 1'b0; class_i = 3'd5; cond_sel_i = 3'd7; count_i = 8'h00;
    flags_i = 8'h00;
    repeat (3) @(negedge clk_i);
    #1;
    checks++;
    if (taken_o !== last.tk || cycles_o !== last.cyc || count_o !== last.cnt ||
        vector_o !== last.vec || valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R9: hold actual tk=%0b cyc=%0d cnt=%0d vec=%h v=%0b, expected tk=%0b cyc=%0d cnt=%0d vec=%h v=0",
               taken_o, cycles_o, count_o, vector_o, valid_o, last.tk, last.cyc, last.cnt, last.vec);
    end

    repeat (2) @(negedge clk_i);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing (actual %0d, expected 0)", q.size(), q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule